// File: doc/BRIEF.md
# Hardware Monitor Control Register

This block is the 8-bit control register of a system hardware monitor, together with the logic that acts on its bits. The host writes it through a plain address/data/write-strobe port. Its bits start and stop the monitoring loop, and they set up and gate the interrupt output. Other bits fire a fixed-length pulse on the reset output, clear the chassis-intrusion latch and set the general-purpose output level.

One bit asks for a soft initialization. That request returns this register to its power-on value. It also sends a one-cycle strobe to the neighbouring status, mask, divisor and resolution register banks so that they reload their defaults. The measurement and limit storage is not touched. An active-low external reset puts the block in the same state as power-on.

The pulse length is set in milliseconds. It is converted to system-clock cycles from a clock-frequency parameter.

Top module: `hwmon_ctrl_reg`

## Requirements
- R1: While `rst_n` is low and right after it rises, `cfg_value` is 8'h08 (only the interrupt-clear bit set). In that state `mon_run`, `irq_out`, `irq_od`, `rst_out`, `ci_clr`, `gpo` and `init_strobe` are all 0.
- R2: A write to `CFG_ADDR` takes effect one cycle after its capturing edge. Then `mon_run` = bit 0 AND NOT bit 3 of the stored value.
- R3: `irq_out` = `irq_req` AND stored bit 1 AND NOT stored bit 3. `irq_od` follows stored bit 2 (1 = open-drain, 0 = open-source).
- R4: While stored bit 3 is 1, `mon_run` and `irq_out` are 0 whatever bits 0 and 1 hold.
- R5: A write with bit 4 = 1 and bit 7 = 0 while `rst_mode` = 1 drives `rst_out` high from the cycle after the capturing edge. It stays high for exactly PULSE_MS × CLK_HZ / 1000 cycles. A further such write during the pulse restarts the full count.
- R6: A write with bit 4 = 1 while `rst_mode` = 0 leaves `rst_out` low.
- R7: A write with bit 5 = 1 and bit 7 = 0 raises `ci_clr` for one cycle, the cycle after the capturing edge.
- R8: `gpo` follows stored bit 6.
- R9: A write with bit 7 = 1 raises `init_strobe` for one cycle and returns `cfg_value` to 8'h08. Every other bit of that write is ignored, and a running reset pulse ends.
- R10: Writes to any address other than `CFG_ADDR` change neither `cfg_value` nor any output.
- R11: Bits 4, 5 and 7 act only as triggers and always read back as 0 in `cfg_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| irq_req | input | 1 | Pending interrupt from the status logic |
| rst_mode | input | 1 | 1 when the reset/OS pin is set up as a reset output |
| cfg_value | output | 8 | Readable register content |
| mon_run | output | 1 | Monitoring loop runs |
| irq_out | output | 1 | Interrupt output asserted |
| irq_od | output | 1 | Interrupt pin drive style: 1 open-drain, 0 open-source |
| rst_out | output | 1 | Timed reset pulse |
| ci_clr | output | 1 | One-cycle chassis-intrusion latch clear |
| gpo | output | 1 | General-purpose output level |
| init_strobe | output | 1 | One-cycle initialization strobe to other banks |

## Verification
Every register result appears in the first cycle after the edge that captures the write: the stored value, the run and interrupt outputs, both strobes and the start of the reset pulse. The bench therefore drives each write at a falling edge and samples at the next falling edge. It then counts `rst_out` high cycles at falling edges and expects exactly the pulse length, or the time to a restart plus the pulse length. All 256 data values are swept, each with `rst_mode` low and with `irq_req` high. For each one the bench computes the stored value and every output arithmetically.

// File: rtl/hwmon_ctrl_reg.sv
module hwmon_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h40,
  parameter int CLK_HZ = 250_000_000,
  parameter int PULSE_MS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              irq_req,
  input  logic              rst_mode,
  output logic [7:0]        cfg_value,
  output logic              mon_run,
  output logic              irq_out,
  output logic              irq_od,
  output logic              rst_out,
  output logic              ci_clr,
  output logic              gpo,
  output logic              init_strobe
);
  localparam int PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [7:0] CFG_RST  = 8'h08;
  localparam logic [7:0] CFG_KEEP = 8'h4F;

  logic [7:0]       cfg_q;
  logic [CNT_W-1:0] cnt_q;

  wire hit        = wr_en && (wr_addr == CFG_ADDR);
  wire do_init    = hit && wr_data[7];
  wire pulse_trig = hit && !wr_data[7] && wr_data[4] && rst_mode;
  wire ci_trig    = hit && !wr_data[7] && wr_data[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= CFG_RST;
      cnt_q       <= '0;
      init_strobe <= 1'b0;
      ci_clr      <= 1'b0;
    end else begin
      init_strobe <= do_init;
      ci_clr      <= ci_trig;
      if (do_init)  cfg_q <= CFG_RST;
      else if (hit) cfg_q <= wr_data & CFG_KEEP;
      if (do_init)             cnt_q <= '0;
      else if (pulse_trig)     cnt_q <= CNT_W'(PULSE_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cfg_value = cfg_q;
  assign mon_run   = cfg_q[0] & ~cfg_q[3];
  assign irq_out   = irq_req & cfg_q[1] & ~cfg_q[3];
  assign irq_od    = cfg_q[2];
  assign gpo       = cfg_q[6];
  assign rst_out   = (cnt_q != '0);

  a_r9_init_restores: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (init_strobe && cfg_value == 8'h08 && !rst_out));

  a_r5_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_trig |=> rst_out);

  a_r6_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && !pulse_trig) |=> !rst_out);

  a_r7_ci_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ci_trig |=> ci_clr);

  a_r10_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CFG_ADDR) |=> ($stable(cfg_value) && !init_strobe && !ci_clr));

  a_r4_clear_gates: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_value[3] |-> (!irq_out && !mon_run));
endmodule

// File: tb/hwmon_ctrl_reg_tb.sv
module hwmon_ctrl_reg_tb_top;
  localparam int P = 100;
  logic clk = 0, rst_n = 0, wr_en = 0, irq_req = 0, rst_mode = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [7:0] cfg_value;
  logic mon_run, irq_out, irq_od, rst_out, ci_clr, gpo, init_strobe;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  hwmon_ctrl_reg #(.ADDR_W(8), .CFG_ADDR(8'h40), .CLK_HZ(10_000), .PULSE_MS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_req(irq_req), .rst_mode(rst_mode), .cfg_value(cfg_value), .mon_run(mon_run),
    .irq_out(irq_out), .irq_od(irq_od), .rst_out(rst_out), .ci_clr(ci_clr), .gpo(gpo),
    .init_strobe(init_strobe));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic count_pulse(output int c);
    c = 0;
    while (rst_out && c < 10 * P) begin
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    logic [7:0] exp_cfg;
    @(negedge clk);
    chk("R1 cfg in reset", cfg_value, 8'h08);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg", cfg_value, 8'h08);
    chk("R1 outputs", {mon_run, irq_out, irq_od, rst_out, ci_clr, gpo, init_strobe}, 0);

    irq_req = 1;
    for (int d = 0; d < 256; d++) begin
      wr(8'h40, 8'(d));
      exp_cfg = d[7] ? 8'h08 : (8'(d) & 8'h4F);
      chk("R11 cfg readback", cfg_value, exp_cfg);
      chk("R2 mon_run", mon_run, exp_cfg[0] & ~exp_cfg[3]);
      chk("R3 irq_out", irq_out, exp_cfg[1] & ~exp_cfg[3]);
      chk("R3 irq_od", irq_od, exp_cfg[2]);
      chk("R8 gpo", gpo, exp_cfg[6]);
      chk("R7 ci_clr", ci_clr, d[5] & ~d[7]);
      chk("R9 init_strobe", init_strobe, d[7]);
      chk("R6 no pulse", rst_out, 0);
    end

    wr(8'h40, 8'h0B);
    chk("R4 halt run", mon_run, 0);
    chk("R4 irq forced off", irq_out, 0);
    wr(8'h40, 8'h03);
    chk("R2 run", mon_run, 1);
    irq_req = 0; @(negedge clk);
    chk("R3 irq follows req", irq_out, 0);

    wr(8'h40, 8'h20);
    @(negedge clk);
    chk("R7 one cycle", ci_clr, 0);

    wr(8'h40, 8'h10);
    repeat (5) @(negedge clk);
    chk("R6 rst_mode low", rst_out, 0);

    rst_mode = 1;
    wr(8'h40, 8'h51);
    count_pulse(c);
    chk("R5 pulse length", c, P);
    chk("R11 bit4 reads 0", cfg_value, 8'h41);

    wr(8'h40, 8'h10);
    repeat (39) @(negedge clk);
    chk("R5 still high", rst_out, 1);
    wr(8'h40, 8'h10);
    count_pulse(c);
    chk("R5 retrigger", c, P);

    wr(8'h40, 8'h10);
    repeat (10) @(negedge clk);
    wr(8'h40, 8'hFF);
    chk("R9 pulse cancelled", rst_out, 0);
    chk("R9 cfg default", cfg_value, 8'h08);
    @(negedge clk);
    chk("R9 strobe one cycle", init_strobe, 0);

    wr(8'h40, 8'h43);
    wr(8'h41, 8'hFF);
    chk("R10 cfg kept", cfg_value, 8'h43);
    chk("R10 no strobes", {init_strobe, ci_clr, rst_out}, 0);
    wr(8'h00, 8'h80);
    chk("R10 no init", init_strobe, 0);

    rst_n = 0;
    @(negedge clk);
    chk("R1 ext reset cfg", cfg_value, 8'h08);
    chk("R1 ext reset gpo", gpo, 0);
    rst_n = 1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule